// File: doc/BRIEF.md
# Phase-Accumulator Serial Clock Generator

This block derives a serial-bus clock (SCK) from a fast reference clock. It does not use an integer counter divider. Instead, a 12-bit phase accumulator adds a step value on every enabled reference cycle. Each carry out of the accumulator is one SCK half-period event, so SCK toggles once per carry. The step comes from a 16-bit frequency word:

- A word of 2048 gives the fastest normal rate, one toggle every two reference cycles.
- Smaller words give proportionally slower rates, with fractional spacing between toggles.
- A double-rate select doubles the step. With a word of 2048 this gives one toggle per reference cycle.

The block also produces two single-cycle strobes, one for driving data out (launch) and one for sampling data in (latch). Each strobe fires together with either the rising or the falling SCK edge, chosen independently. A polarity input sets the level SCK rests at while no transfer is running. An enable input marks a transfer. A restart option clears the accumulator in the first enabled cycle, so the first SCK edge always comes at the same delay after the transfer begins.

Top module: `phacc_sck_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `sck` takes the value of `cpol` and both `launch_stb` and `latch_stb` are 0 after that edge.
- R2: While `en` is low, `sck` equals `cpol` and both strobes are 0 from the next clock edge on. The accumulator keeps its value while `en` is low.
- R3: In each enabled cycle the 12-bit accumulator adds the step. Without double rate the step equals the frequency word. `sck` toggles exactly in the cycles where the sum reaches 4096 or more, and the sum is then reduced by 4096. After k enabled cycles from a cleared accumulator, `sck` has toggled floor(k*step/4096) times.
- R4: A frequency word of 0 is used as 1. Any word above 2048 is used as 2048.
- R5: With `dbl_rate` high the step is twice the (clamped) word. With word 2048, `sck` toggles in every enabled cycle.
- R6: With `restart_en` high, the first enabled cycle after an idle cycle sums from 0. With `restart_en` low, the sum continues from the value held during idle.
- R7: `launch_stb` is 1 for exactly the cycles in which `sck` has just changed to the level given by `launch_rise` (1 = rising edge, 0 = falling edge). Otherwise it is 0.
- R8: `latch_stb` is 1 for exactly the cycles in which `sck` has just changed to the level given by `latch_rise` (1 = rising edge, 0 = falling edge). Otherwise it is 0.
- R9: The idle level of `sck` is `cpol`. The first edge of a transfer leaves that level, and a change of `cpol` during idle reaches `sck` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Transfer active |
| freq_word | input | 16 | Frequency word; 2048 gives the fastest normal rate |
| dbl_rate | input | 1 | Double the accumulator step |
| restart_en | input | 1 | Clear the accumulator phase at the start of each transfer |
| cpol | input | 1 | Idle level of SCK |
| launch_rise | input | 1 | Launch strobe on the rising (1) or falling (0) SCK edge |
| latch_rise | input | 1 | Latch strobe on the rising (1) or falling (0) SCK edge |
| sck | output | 1 | Serial clock |
| launch_stb | output | 1 | One-cycle strobe to drive out the next data bit |
| latch_stb | output | 1 | One-cycle strobe to sample the incoming data bit |

## Verification
A wrong accumulator value shows at `sck` as a toggle that comes one or more cycles early or late. How soon depends on the step: it can appear within two cycles at the fastest rate, but only after thousands of cycles with a word of 1. The bench therefore follows its own running sum cycle by cycle and compares every toggle position, not just a total count. A held phase that is corrupted during idle shows only on the first edge of the next transfer when restart is off, so that case is checked against the first enabled cycle. A wrong edge register shows at once as a strobe whose cycle differs from the cycle of the SCK change, or as a strobe on the wrong edge direction.

// File: rtl/phacc_sck_pkg.sv
package phacc_sck_pkg;

    localparam int ACC_W_DEF  = 12;
    localparam int FREQ_W_DEF = 16;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_sel_e;

    typedef struct packed {
        logic      idle_lvl;
        edge_sel_e launch_edge;
        edge_sel_e latch_edge;
    } edge_cfg_t;

    typedef struct packed {
        logic sck;
        logic launch;
        logic latch;
    } sck_out_t;

endpackage

// File: rtl/phacc_step_norm.sv
module phacc_step_norm
    import phacc_sck_pkg::*;
#(
    parameter int ACC_W  = ACC_W_DEF,
    parameter int FREQ_W = FREQ_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FREQ_W-1:0] word,
    input  logic              dbl,
    output logic [ACC_W:0]    step
);
    localparam int UNIT = 1 << (ACC_W - 1);

    logic [ACC_W-1:0] w_small;

    always_comb begin
        if (word == '0)
            w_small = ACC_W'(1);
        else if (word > FREQ_W'(UNIT))
            w_small = ACC_W'(UNIT);
        else
            w_small = word[ACC_W-1:0];
    end

    assign step = dbl ? {w_small, 1'b0} : {1'b0, w_small};

    // R4: the step is never zero and never exceeds one full accumulator wrap
    p_step_range_r4: assert property (@(posedge clk) disable iff (rst)
        (step != '0) && (step <= (ACC_W+1)'(2 * UNIT)));

endmodule

// File: rtl/phacc_accum.sv
module phacc_accum
    import phacc_sck_pkg::*;
#(
    parameter int ACC_W = ACC_W_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic           clr_on_start,
    input  logic [ACC_W:0] step,
    output logic           tick
);
    logic [ACC_W-1:0] acc_q;
    logic             en_q;
    logic             start;
    logic [ACC_W-1:0] base;
    logic [ACC_W:0]   sum;

    assign start = en && !en_q;
    assign base  = (start && clr_on_start) ? '0 : acc_q;
    assign sum   = {1'b0, base} + step;
    assign tick  = en && sum[ACC_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            en_q  <= 1'b0;
        end else begin
            en_q <= en;
            if (en)
                acc_q <= sum[ACC_W-1:0];
        end
    end

    // R2: phase is frozen while no transfer runs
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> (acc_q == $past(acc_q)));

    // R6: a cleared start lands the phase on the low bits of the step
    p_restart_phase_r6: assert property (@(posedge clk) disable iff (rst)
        (start && clr_on_start) |=> (acc_q == $past(step[ACC_W-1:0])));

endmodule

// File: rtl/phacc_edges.sv
module phacc_edges
    import phacc_sck_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      tick,
    input  edge_cfg_t cfg,
    output sck_out_t  out
);
    sck_out_t  q;
    logic      nxt_lvl;

    assign nxt_lvl = !q.sck;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            q.sck    <= cfg.idle_lvl;
            q.launch <= 1'b0;
            q.latch  <= 1'b0;
        end else if (tick) begin
            q.sck    <= nxt_lvl;
            q.launch <= (nxt_lvl == logic'(cfg.launch_edge));
            q.latch  <= (nxt_lvl == logic'(cfg.latch_edge));
        end else begin
            q.launch <= 1'b0;
            q.latch  <= 1'b0;
        end
    end

    assign out = q;

    // R9: after an idle cycle the clock rests at the polarity level
    p_idle_level_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (q.sck == $past(cfg.idle_lvl)));

    // R7: launch strobe only together with an SCK change in the chosen direction
    p_launch_edge_r7: assert property (@(posedge clk) disable iff (rst)
        q.launch |-> ((q.sck != $past(q.sck)) && (q.sck == $past(logic'(cfg.launch_edge)))));

    // R8: latch strobe only together with an SCK change in the chosen direction
    p_latch_edge_r8: assert property (@(posedge clk) disable iff (rst)
        q.latch |-> ((q.sck != $past(q.sck)) && (q.sck == $past(logic'(cfg.latch_edge)))));

endmodule

// File: rtl/phacc_sck_gen.sv
module phacc_sck_gen
    import phacc_sck_pkg::*;
#(
    parameter int ACC_W  = ACC_W_DEF,
    parameter int FREQ_W = FREQ_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [FREQ_W-1:0] freq_word,
    input  logic              dbl_rate,
    input  logic              restart_en,
    input  logic              cpol,
    input  logic              launch_rise,
    input  logic              latch_rise,
    output logic              sck,
    output logic              launch_stb,
    output logic              latch_stb
);
    logic [ACC_W:0] step;
    logic           tick;
    edge_cfg_t      cfg;
    sck_out_t       outs;

    assign cfg.idle_lvl    = cpol;
    assign cfg.launch_edge = edge_sel_e'(launch_rise);
    assign cfg.latch_edge  = edge_sel_e'(latch_rise);

    phacc_step_norm #(.ACC_W(ACC_W), .FREQ_W(FREQ_W)) u_norm (
        .clk  (clk),
        .rst  (rst),
        .word (freq_word),
        .dbl  (dbl_rate),
        .step (step)
    );

    phacc_accum #(.ACC_W(ACC_W)) u_accum (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .clr_on_start (restart_en),
        .step         (step),
        .tick         (tick)
    );

    phacc_edges u_edges (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .tick (tick),
        .cfg  (cfg),
        .out  (outs)
    );

    assign sck        = outs.sck;
    assign launch_stb = outs.launch;
    assign latch_stb  = outs.latch;

    // R3: an edge never appears without an enabled transfer
    p_edge_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
        (sck != $past(sck)) |-> ($past(en) || ($past(cpol) != $past(sck))));

endmodule

// File: tb/phacc_sck_gen_bench.sv
module phacc_sck_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [15:0] freq_word = 16'd2048;
    logic        dbl_rate = 1'b0;
    logic        restart_en = 1'b1;
    logic        cpol = 1'b0;
    logic        launch_rise = 1'b1;
    logic        latch_rise = 1'b0;
    logic        sck, launch_stb, latch_stb;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    int model_acc = 0;

    always #5 clk = ~clk;

    phacc_sck_gen u_phacc_sck_gen (
        .clk(clk), .rst(rst), .en(en), .freq_word(freq_word),
        .dbl_rate(dbl_rate), .restart_en(restart_en), .cpol(cpol),
        .launch_rise(launch_rise), .latch_rise(latch_rise),
        .sck(sck), .launch_stb(launch_stb), .latch_stb(latch_stb)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // run one transfer of n cycles and compare every cycle against a running sum
    task automatic run_xfer(input string req, input int n, input int word,
                            input bit dbl, input bit restart);
        int w, step, exp_tog, act_tog, pos_err, ln_err, lt_err;
        logic prev;
        w = (word == 0) ? 1 : ((word > 2048) ? 2048 : word);
        step = dbl ? 2 * w : w;
        exp_tog = 0; act_tog = 0; pos_err = 0; ln_err = 0; lt_err = 0;
        @(negedge clk);
        freq_word = 16'(word); dbl_rate = dbl; restart_en = restart; en = 1'b1;
        if (restart) model_acc = 0;
        prev = sck;
        for (int i = 0; i < n; i++) begin
            bit et, at;
            @(negedge clk);
            model_acc += step;
            et = (model_acc >= 4096);
            if (et) model_acc -= 4096;
            at = (sck != prev);
            if (et) exp_tog++;
            if (at) act_tog++;
            if (et != at) pos_err++;
            if (launch_stb != (at && (sck == launch_rise))) ln_err++;
            if (latch_stb != (at && (sck == latch_rise))) lt_err++;
            prev = sck;
        end
        chk(req, "toggle count", act_tog, exp_tog);
        chk(req, "toggle positions off", pos_err, 0);
        chk("R7", "launch strobe mismatches", ln_err, 0);
        chk("R8", "latch strobe mismatches", lt_err, 0);
        en = 1'b0;
        @(negedge clk);
        chk("R2", "idle sck level", int'(sck), int'(cpol));
        chk("R2", "idle strobes", int'(launch_stb) + int'(latch_stb), 0);
    endtask

    task automatic t_reset();
        chk("R1", "sck after reset", int'(sck), 0);
        chk("R1", "strobes after reset", int'(launch_stb) + int'(latch_stb), 0);
    endtask

    task automatic t_rate();
        run_xfer("R3", 40, 1024, 1'b0, 1'b1);
        run_xfer("R3", 120, 1000, 1'b0, 1'b1);
        run_xfer("R3", 60, 2048, 1'b0, 1'b1);
    endtask

    task automatic t_word_limits();
        run_xfer("R4", 4100, 0, 1'b0, 1'b1);
        run_xfer("R4", 30, 40000, 1'b0, 1'b1);
    endtask

    task automatic t_double();
        run_xfer("R5", 20, 2048, 1'b1, 1'b1);
        run_xfer("R5", 50, 700, 1'b1, 1'b1);
        run_xfer("R5", 20, 3000, 1'b1, 1'b1);
    endtask

    task automatic t_restart();
        // leave the phase at 2048, then resume without clearing: edge in first cycle
        run_xfer("R6", 1, 2048, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        run_xfer("R6", 6, 2048, 1'b0, 1'b0);
        // same history with clearing: first edge on the second cycle
        run_xfer("R6", 1, 2048, 1'b0, 1'b1);
        run_xfer("R6", 6, 2048, 1'b0, 1'b1);
    endtask

    task automatic t_polarity();
        @(negedge clk);
        cpol = 1'b1; launch_rise = 1'b0; latch_rise = 1'b1;
        @(negedge clk);
        chk("R9", "idle level follows polarity", int'(sck), 1);
        run_xfer("R9", 33, 1500, 1'b0, 1'b1);
        launch_rise = 1'b1; latch_rise = 1'b1;
        run_xfer("R7", 25, 2048, 1'b1, 1'b1);
        launch_rise = 1'b0; latch_rise = 1'b0;
        run_xfer("R8", 25, 512, 1'b0, 1'b1);
        @(negedge clk);
        cpol = 1'b0;
        @(negedge clk);
        chk("R9", "idle level back low", int'(sck), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_rate();
        t_word_limits();
        t_double();
        t_restart();
        t_polarity();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule